// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit timer channel. Counting is paced by `tick_i`, a one-cycle enable pulse in the system clock domain, and qualified by the `gate_i` level. A load strobe captures a mode code, a reload value N and a decimal-format flag, and the channel restarts counting at once. The channel drives a mode-dependent waveform on `out_o`. It also presents the live count on `count_o` for readback.

Six behaviours are supported:
- a one-shot that rises after N ticks and stays high (code 0);
- a gate-retriggered one-shot (code 1);
- a periodic one-tick pulse (code 2);
- a square wave (code 3);
- a single one-tick strobe that the load starts (code 4);
- a single one-tick strobe that the gate retriggers (code 5).

Codes 6 and 7 alias codes 2 and 3. The decimal-format flag has no effect on counting. It is only held for status reporting on `bcd_o`.

Top module: `interval_counter`

## Requirements
- R1: After reset the stored mode is 3, N is 65536 (readback 0x0000), `bcd_o` is 0 and `out_o` is high.
- R2: A cycle with `load_i` high captures `mode_i`, `reload_i` and `bcd_i` and restarts counting. The next cycle shows `count_o` equal to the reload value. A tick in the same cycle as a load is discarded.
- R3: A reload value of 0 is treated as N = 65536, so readback shows 0x0000 and the first tick gives 0xFFFF.
- R4: In mode 0 `out_o` is low after a load and goes high after the Nth counted tick, then stays high until the next load. While `gate_i` is low, ticks are not counted.
- R5: In mode 1 `out_o` goes low on a load or on a gate rising edge and returns high after N ticks. The gate level does not pause counting.
- R6: In mode 2 `out_o` is high from the Nth tick of each period until the next tick, and low otherwise. The count reloads by itself, and readback is N minus (ticks mod N).
- R7: In mode 3 `out_o` is high while the phase (ticks mod N) is below (N+1)/2, so for odd N the high phase is one tick longer. Readback is N minus (2 x phase mod N), so it falls by two per tick.
- R8: In modes 4 and 5 `out_o` is high only between the Nth and (N+1)th tick, then low until a restart. In mode 4 a low gate pauses counting.
- R9: A gate rising edge restarts counting from N in modes 1, 2, 3 and 5. In modes 0 and 4 it has no effect on the count.
- R10: In modes 0, 1, 4 and 5 readback drops by one per counted tick and wraps modulo 2^16 past zero.
- R11: Mode codes 6 and 7 behave as codes 2 and 3. `mode_o` returns the code as written.
- R12: Without a tick, a load or a restart, `count_o` and `out_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counting-clock enable, one cycle per count |
| gate_i | input | 1 | Gate level, edge-detected internally |
| load_i | input | 1 | Strobe that captures configuration and restarts |
| mode_i | input | 3 | Mode code 0 to 7 |
| bcd_i | input | 1 | Decimal-format flag, stored only |
| reload_i | input | 16 | Reload value N (0 means 65536) |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Live current count |
| mode_o | output | 3 | Stored mode code |
| bcd_o | output | 1 | Stored decimal-format flag |

## Verification
Every result is due one clock after the rising edge that samples its cause:
- a load strobe;
- a counted tick;
- a gate rising edge, which the internal gate register turns into a one-cycle restart at that same edge.

The bench changes inputs only on falling edges. It reads `out_o` and `count_o` on the next falling edge, after exactly the number of rising edges that the stimulus spans. Held-tick bursts therefore map one-to-one onto counted ticks, and each expected value follows directly from N and the tick total.

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic [CW-1:0] reload_i,
  output logic          out_o,
  output logic [CW-1:0] count_o,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);
  localparam int NW = CW + 1;
  localparam int PW = CW + 2;

  logic [2:0]    mode_q;
  logic          bcd_q, gate_q, run_q, past_q;
  logic [NW-1:0] n_q, ph_q;

  wire [2:0] m = (mode_q[2] & mode_q[1]) ? {1'b0, mode_q[1:0]} : mode_q;   // R11
  wire periodic = (m == 3'd2) || (m == 3'd3);
  wire pausable = (m == 3'd0) || (m == 3'd4);
  wire retrig   = periodic || (m == 3'd1) || (m == 3'd5);
  wire rise     = gate_i & ~gate_q;
  wire restart  = load_i | (rise & retrig);
  wire en       = tick_i & (~pausable | gate_i);

  wire [NW-1:0] one    = {{(NW-1){1'b0}}, 1'b1};
  wire [NW-1:0] ph_inc = ph_q + one;
  wire [NW-1:0] new_n  = (reload_i == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, reload_i};
  wire [NW-1:0] half   = (n_q >> 1) + {{(NW-1){1'b0}}, n_q[0]};
  wire [PW-1:0] twice  = {ph_q, 1'b0};

  logic [NW-1:0] wrap, sub;
  assign wrap = (twice >= {1'b0, n_q}) ? NW'(twice - {1'b0, n_q}) : NW'(twice);
  assign sub  = (m == 3'd3) ? wrap : ph_q;
  assign count_o = CW'(n_q - sub);

  always_comb begin
    case (m)
      3'd0, 3'd1: out_o = run_q;
      3'd2:       out_o = run_q & (ph_q == '0);
      3'd3:       out_o = ph_q < half;
      default:    out_o = run_q & ~past_q;
    endcase
  end

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd3;
      bcd_q  <= 1'b0;
      n_q    <= {1'b1, {CW{1'b0}}};
      ph_q   <= '0;
      run_q  <= 1'b0;
      past_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (load_i) begin
        mode_q <= mode_i;
        bcd_q  <= bcd_i;
        n_q    <= new_n;
      end
      if (restart) begin
        ph_q   <= '0;
        run_q  <= 1'b0;
        past_q <= 1'b0;
      end else if (en) begin
        if (periodic) begin
          ph_q  <= (ph_inc == n_q) ? '0 : ph_inc;
          run_q <= 1'b1;
        end else begin
          ph_q <= ph_inc;
          if (ph_inc == n_q) run_q <= 1'b1;
          if (run_q) past_q <= 1'b1;
        end
      end
    end
  end

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart) |=> ($stable(count_o) && $stable(out_o)));

  assert_step_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !periodic) |=> (count_o == ($past(count_o) - {{(CW-1){1'b0}}, 1'b1})));

  assert_stay_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((m == 3'd0) && out_o && !load_i) |=> out_o);

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (((m == 3'd4) || (m == 3'd5)) && out_o && en && !restart) |=> !out_o);

  assert_short_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((m == 3'd2) && (n_q != one) && out_o && en && !restart) |=> !out_o);

  assert_gate_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && retrig && !load_i) |=> (count_o == $past(n_q[CW-1:0])));
endmodule

// File: tb/interval_counter_tb.sv
`timescale 1ns/1ps
module interval_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, gate_i = 1'b1, load_i = 1'b0, bcd_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [15:0] reload_i = 16'd0;
  logic        out_o, bcd_o;
  logic [15:0] count_o;
  logic [2:0]  mode_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  interval_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i), .load_i(load_i),
    .mode_i(mode_i), .bcd_i(bcd_i), .reload_i(reload_i),
    .out_o(out_o), .count_o(count_o), .mode_o(mode_o), .bcd_o(bcd_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic load(input logic [2:0] md, input logic [15:0] n, input logic b);
    mode_i = md; reload_i = n; bcd_i = b; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic gate_edge();
    gate_i = 1'b0; idle(1);
    gate_i = 1'b1; idle(1);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode_o, 3);
    chk("R1 count", count_o, 16'h0000);
    chk("R1 out", out_o, 1);
    chk("R1 bcd", bcd_o, 0);
    ticks(1);
    chk("R7 count by two", count_o, 16'hFFFE);
  endtask

  task automatic t_mode0();
    gate_i = 1'b1; idle(2);
    load(3'd0, 16'd5, 1'b0);
    chk("R2 load count", count_o, 5);
    chk("R4 out low", out_o, 0);
    ticks(4);
    chk("R4 before N", out_o, 0);
    chk("R10 count", count_o, 1);
    ticks(1);
    chk("R4 at N", out_o, 1);
    ticks(2);
    chk("R4 stays high", out_o, 1);
    chk("R10 wrap", count_o, 16'hFFFE);
    gate_i = 1'b0;
    load(3'd0, 16'd5, 1'b0);
    ticks(3);
    chk("R4 gate pause", count_o, 5);
    gate_i = 1'b1; idle(1);
    chk("R9 mode0 edge ignored", count_o, 5);
    ticks(2);
    chk("R4 resumed", count_o, 3);
  endtask

  task automatic t_mode1();
    load(3'd1, 16'd4, 1'b0);
    chk("R5 low after load", out_o, 0);
    ticks(4);
    chk("R5 high after N", out_o, 1);
    chk("R5 count", count_o, 0);
    gate_edge();
    chk("R9 mode1 restart", count_o, 4);
    chk("R5 low on trigger", out_o, 0);
    gate_i = 1'b0;
    ticks(2);
    chk("R5 no pause", count_o, 2);
    gate_i = 1'b1; idle(2);
  endtask

  task automatic t_mode2();
    load(3'd2, 16'd3, 1'b0);
    chk("R6 out low", out_o, 0);
    ticks(2);
    chk("R6 count", count_o, 1);
    chk("R6 out low mid", out_o, 0);
    ticks(1);
    chk("R6 pulse", out_o, 1);
    chk("R6 reload", count_o, 3);
    ticks(1);
    chk("R6 pulse ends", out_o, 0);
    chk("R6 count 2", count_o, 2);
    gate_edge();
    chk("R9 mode2 restart", count_o, 3);
    chk("R9 mode2 out", out_o, 0);
    ticks(3);
    chk("R6 pulse after restart", out_o, 1);
  endtask

  task automatic t_mode3();
    load(3'd3, 16'd5, 1'b0);
    chk("R7 start high", out_o, 1);
    chk("R7 start count", count_o, 5);
    ticks(2);
    chk("R7 high phase", out_o, 1);
    chk("R7 count p2", count_o, 1);
    ticks(1);
    chk("R7 low after 3", out_o, 0);
    chk("R7 count p3", count_o, 4);
    ticks(1);
    chk("R7 low p4", out_o, 0);
    chk("R7 count p4", count_o, 2);
    ticks(1);
    chk("R7 period wraps", out_o, 1);
    ticks(3);
    gate_edge();
    chk("R9 mode3 restart", count_o, 5);
    chk("R9 mode3 out", out_o, 1);
  endtask

  task automatic t_mode4();
    load(3'd4, 16'd3, 1'b0);
    chk("R8 out low", out_o, 0);
    ticks(3);
    chk("R8 strobe", out_o, 1);
    chk("R8 count", count_o, 0);
    ticks(1);
    chk("R8 strobe ends", out_o, 0);
    chk("R10 wrap m4", count_o, 16'hFFFF);
    ticks(5);
    chk("R8 stays low", out_o, 0);
    gate_i = 1'b0;
    load(3'd4, 16'd3, 1'b0);
    ticks(2);
    chk("R8 gate pause", count_o, 3);
    gate_i = 1'b1;
    ticks(1);
    chk("R8 resumed", count_o, 2);
    gate_edge();
    chk("R9 mode4 edge ignored", count_o, 2);
    ticks(2);
    chk("R8 strobe after pause", out_o, 1);
  endtask

  task automatic t_mode5();
    load(3'd5, 16'd2, 1'b0);
    ticks(2);
    chk("R8 m5 strobe", out_o, 1);
    ticks(1);
    chk("R8 m5 ends", out_o, 0);
    gate_edge();
    chk("R9 mode5 restart", count_o, 2);
    chk("R9 mode5 out", out_o, 0);
    ticks(2);
    chk("R8 m5 retrig strobe", out_o, 1);
  endtask

  task automatic t_alias();
    load(3'd6, 16'd3, 1'b0);
    chk("R11 mode_o 6", mode_o, 6);
    ticks(3);
    chk("R11 6 as 2 pulse", out_o, 1);
    chk("R11 6 as 2 count", count_o, 3);
    load(3'd7, 16'd5, 1'b0);
    ticks(3);
    chk("R11 7 as 3 out", out_o, 0);
    chk("R11 7 as 3 count", count_o, 4);
  endtask

  task automatic t_zero_and_priority();
    load(3'd0, 16'd0, 1'b0);
    chk("R3 zero count", count_o, 0);
    chk("R3 zero out", out_o, 0);
    ticks(1);
    chk("R3 first tick", count_o, 16'hFFFF);
    chk("R3 not done", out_o, 0);
    load(3'd0, 16'd10, 1'b0);
    idle(5);
    chk("R12 idle count", count_o, 10);
    chk("R12 idle out", out_o, 0);
    tick_i = 1'b1;
    load(3'd0, 16'd7, 1'b0);
    tick_i = 1'b0;
    chk("R2 load wins over tick", count_o, 7);
    load(3'd0, 16'h0010, 1'b1);
    chk("R2 bcd stored", bcd_o, 1);
    ticks(1);
    chk("R2 bcd no effect", count_o, 16'h000F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_alias();
    t_zero_and_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule